// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

This block is a single-port synchronous memory with a pipelined interface that never needs an idle cycle when the bus direction changes. Address, command and byte enables are taken on a rising clock edge. A read places its word in an output register and drives it during the following cycle. A write supplies its data two active edges after the command. As a result, the data slot of every command falls the same distance behind its command, and reads and writes can be mixed freely on consecutive cycles.

Storage is organised as words of `NBYTES` nine-bit bytes, and each byte has its own write strobe. The device responds only when all three chip selects are active. An active-low clock enable stops the whole pipeline, including the storage array and the output register. An asynchronous output enable gates the data drivers. The data bus is split into an input, an output and a drive-enable so that the pad ring can build the tristate. A read that follows a write to the same word, before that write reaches the array, receives the write's bytes merged into the stored word.

Top module: `sram_nbt`

## Requirements
- R1: A read issued at active edge k loads the output register at active edge k+1, and `dq_o` holds the word from that edge until the next active edge.
- R2: A write issued at active edge k takes `dq_i` at active edge k+2. Byte b is bits [9b+8:9b], and it is stored only when `bw_n[b]` was 0 with the command.
- R3: Reads and writes may alternate on consecutive active edges with no idle cycle, and each returns or stores the correct word.
- R4: A command counts only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. With any other combination no write happens and no read is performed.
- R5: `dq_t` is 0 during the output slot of a write, a deselected cycle or an idle cycle.
- R6: `dq_t` equals the read slot qualified by `oe_n`=0, and it follows `oe_n` with no clock edge.
- R7: While `cke_n`=1, edges are ignored: no command is taken, no write data is captured, and `dq_o` and `dq_t` hold their values.
- R8: A read to the word of the write issued one active edge earlier returns that write's enabled bytes merged over the stored word.
- R9: After reset, `dq_t` is 0 and `dq_o` is 0.
- R10: `we_n`=0 with the device selected issues a write, and `we_n`=1 issues a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cke_n | input | 1 | Clock enable, active low |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write command when low, read when high |
| addr | input | ADDR_W | Word address |
| bw_n | input | NBYTES | Per-byte write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | 9*NBYTES | Write data from the bus |
| dq_o | output | 9*NBYTES | Read data to the bus |
| dq_t | output | 1 | Bus drive enable |

## Verification
A wrong pipeline stage shows up at the ports one active edge after the fault. It appears either as a read whose word arrives a slot early or late, or as a drive enable that is raised during a write's data slot, where it would collide with incoming data. Corruption in the array or in the merge path shows up as a mismatched `dq_o` on the first read of the affected word. The sweeps read every address back directly after each fill, so such an error appears within one pass over the address space. A clock-enable fault shows as `dq_o` or `dq_t` changing across a frozen edge, which is visible in the same cycle.

// File: rtl/sram_nbt_pkg.sv
package sram_nbt_pkg;
  localparam int BYTE_W = 9;
  typedef enum logic [1:0] {CMD_IDLE = 2'd0, CMD_RD = 2'd1, CMD_WR = 2'd2} cmd_e;
endpackage

// File: rtl/sram_nbt_ctrl.sv
module sram_nbt_ctrl
  import sram_nbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst_q,
  input  logic              cke,
  input  logic              sel,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBYTES-1:0] bw_n,
  output cmd_e              s1_kind,
  output logic [ADDR_W-1:0] s1_addr,
  output cmd_e              s2_kind,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [NBYTES-1:0] s2_bw_n
);
  cmd_e              s1_kind_d, s2_kind_d;
  logic [ADDR_W-1:0] s1_addr_d, s2_addr_d;
  logic [NBYTES-1:0] s1_bw_d, s2_bw_d, s1_bw_q;

  always_comb begin
    s1_kind_d = s1_kind;
    s1_addr_d = s1_addr;
    s1_bw_d   = s1_bw_q;
    s2_kind_d = s2_kind;
    s2_addr_d = s2_addr;
    s2_bw_d   = s2_bw_n;
    if (cke) begin
      if (!sel)      s1_kind_d = CMD_IDLE;
      else if (we_n) s1_kind_d = CMD_RD;
      else           s1_kind_d = CMD_WR;
      s1_addr_d = addr;
      s1_bw_d   = bw_n;
      s2_kind_d = s1_kind;
      s2_addr_d = s1_addr;
      s2_bw_d   = s1_bw_q;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s1_kind <= CMD_IDLE;
      s1_addr <= '0;
      s1_bw_q <= '1;
      s2_kind <= CMD_IDLE;
      s2_addr <= '0;
      s2_bw_n <= '1;
    end else begin
      s1_kind <= s1_kind_d;
      s1_addr <= s1_addr_d;
      s1_bw_q <= s1_bw_d;
      s2_kind <= s2_kind_d;
      s2_addr <= s2_addr_d;
      s2_bw_n <= s2_bw_d;
    end
  end
endmodule

// File: rtl/sram_nbt_array.sv
module sram_nbt_array
  import sram_nbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [NBYTES-1:0]        wr_bw_n,
  input  logic [NBYTES*BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [NBYTES*BYTE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] lane [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && !wr_bw_n[b]) lane[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
    end
    assign rd_data[b*BYTE_W +: BYTE_W] = lane[rd_addr];
  end
endmodule

// File: rtl/sram_nbt_fwd.sv
module sram_nbt_fwd
  import sram_nbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [NBYTES*BYTE_W-1:0] rd_raw,
  input  logic                     wr_valid,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [NBYTES-1:0]        wr_bw_n,
  input  logic [NBYTES*BYTE_W-1:0] wr_data,
  output logic [NBYTES*BYTE_W-1:0] merged
);
  logic hit;
  assign hit = wr_valid && (wr_addr == rd_addr);

  for (genvar b = 0; b < NBYTES; b++) begin : g_merge
    assign merged[b*BYTE_W +: BYTE_W] = (hit && !wr_bw_n[b]) ?
        wr_data[b*BYTE_W +: BYTE_W] : rd_raw[b*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/sram_nbt.sv
module sram_nbt
  import sram_nbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cke_n,
  input  logic                     ce1_n,
  input  logic                     ce2,
  input  logic                     ce3_n,
  input  logic                     we_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NBYTES-1:0]        bw_n,
  input  logic                     oe_n,
  input  logic [NBYTES*BYTE_W-1:0] dq_i,
  output logic [NBYTES*BYTE_W-1:0] dq_o,
  output logic                     dq_t
);
  localparam int DW = NBYTES * BYTE_W;

  logic              rst_m, rst_q;
  logic              cke, sel, wr_en;
  cmd_e              s1_kind, s2_kind;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [NBYTES-1:0] s2_bw_n;
  logic [DW-1:0]     rd_raw, merged, dout_d, dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  assign cke   = !cke_n;
  assign sel   = !ce1_n && ce2 && !ce3_n;
  assign wr_en = cke && (s2_kind == CMD_WR);

  sram_nbt_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_ctrl (
    .clk(clk), .rst_q(rst_q), .cke(cke), .sel(sel), .we_n(we_n),
    .addr(addr), .bw_n(bw_n),
    .s1_kind(s1_kind), .s1_addr(s1_addr),
    .s2_kind(s2_kind), .s2_addr(s2_addr), .s2_bw_n(s2_bw_n)
  );

  sram_nbt_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_array (
    .clk(clk), .wr_en(wr_en), .wr_addr(s2_addr), .wr_bw_n(s2_bw_n),
    .wr_data(dq_i), .rd_addr(s1_addr), .rd_data(rd_raw)
  );

  sram_nbt_fwd #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_fwd (
    .rd_addr(s1_addr), .rd_raw(rd_raw), .wr_valid(wr_en),
    .wr_addr(s2_addr), .wr_bw_n(s2_bw_n), .wr_data(dq_i), .merged(merged)
  );

  always_comb begin
    dout_d = dout_q;
    if (cke && (s1_kind == CMD_RD)) dout_d = merged;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) dout_q <= '0;
    else        dout_q <= dout_d;
  end

  assign dq_o = dout_q;
  assign dq_t = (s2_kind == CMD_RD) && !oe_n;
endmodule

// File: rtl/sram_nbt_chk.sv
module sram_nbt_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_q,
  input logic          cke_n,
  input logic          ce1_n,
  input logic          ce2,
  input logic          ce3_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          dq_t,
  input logic [DW-1:0] dq_o
);
  logic k_rd1, k_rd2;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      k_rd1 <= 1'b0;
      k_rd2 <= 1'b0;
    end else if (!cke_n) begin
      k_rd1 <= !ce1_n && ce2 && !ce3_n && we_n;
      k_rd2 <= k_rd1;
    end
  end

  a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_q)
    (k_rd2 && !oe_n) |-> dq_t);
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_q)
    !k_rd2 |-> !dq_t);
  a_r6_oe_off: assert property (@(posedge clk) disable iff (!rst_q)
    oe_n |-> !dq_t);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_q)
    cke_n |=> $stable(dq_o));
  a_r9_reset_quiet: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(rst_q) |-> !dq_t);
endmodule

bind sram_nbt sram_nbt_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_q(rst_q), .cke_n(cke_n), .ce1_n(ce1_n), .ce2(ce2),
  .ce3_n(ce3_n), .we_n(we_n), .oe_n(oe_n), .dq_t(dq_t), .dq_o(dq_o)
);

// File: tb/tb_sram_nbt.sv
module tb_sram_nbt;
  localparam int PER = 10;
  localparam int AW  = 4;
  localparam int NB  = 2;
  localparam int DW  = NB * 9;
  localparam int N   = 1 << AW;

  logic clk, rst_n, cke_n, ce1_n, ce2, ce3_n, we_n, oe_n, dq_t;
  logic [AW-1:0] addr;
  logic [NB-1:0] bw_n;
  logic [DW-1:0] dq_i, dq_o;

  int total, bad, cyc;
  bit done;
  logic [DW-1:0] model [N];
  int desel_mode;

  // bench shadow pipeline: stage 1 and 2 entries
  bit b1_rd, b1_wr, b2_rd, b2_wr;
  logic [DW-1:0] b1_val, b2_val;
  string b1_tag, b2_tag;

  sram_nbt #(.ADDR_W(AW), .NBYTES(NB)) dut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .we_n(we_n), .addr(addr), .bw_n(bw_n), .oe_n(oe_n),
    .dq_i(dq_i), .dq_o(dq_o), .dq_t(dq_t)
  );

  initial clk = 1'b0;
  always #(PER/2) clk = ~clk;

  function automatic logic [DW-1:0] pat(int a, int s);
    return DW'((a * 2731 + s * 40503 + 17) ^ (a << 9) ^ (s << 4));
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // one clock: check output slot, drive inputs, advance shadow on active edge
  task automatic step(bit sel, bit wr, int a, logic [NB-1:0] bw, logic [DW-1:0] wd,
                      bit ck, string tag);
    @(negedge clk);
    if (b2_rd) begin
      chk(dq_t == !oe_n, "R6 drive", DW'(dq_t), DW'(!oe_n));
      if (!oe_n) chk(dq_o == b2_val, b2_tag, dq_o, b2_val);
    end else begin
      chk(dq_t == 1'b0, "R5 quiet slot", DW'(dq_t), '0);
    end
    cke_n = !ck;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    if (!sel) begin
      case (desel_mode % 3)
        0: ce1_n = 1'b1;
        1: ce2   = 1'b0;
        default: ce3_n = 1'b1;
      endcase
    end
    we_n = !wr;
    addr = AW'(a);
    bw_n = bw;
    dq_i = b2_wr ? b2_val : DW'(cyc * 977 + 3);
    if (ck) begin
      if (sel && wr) begin
        for (int b = 0; b < NB; b++)
          if (!bw[b]) model[a][b*9 +: 9] = wd[b*9 +: 9];
      end
    end
    @(posedge clk);
    cyc++;
    #1;
    if (ck) begin
      b2_rd = b1_rd; b2_wr = b1_wr; b2_val = b1_val; b2_tag = b1_tag;
      b1_rd = sel && !wr;
      b1_wr = sel && wr;
      b1_val = (sel && wr) ? wd : model[a];
      b1_tag = tag;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, '1, '0, 1'b1, "R5");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; cyc = 0; done = 0; desel_mode = 0;
    b1_rd = 0; b1_wr = 0; b2_rd = 0; b2_wr = 0; b1_val = '0; b2_val = '0;
    b1_tag = ""; b2_tag = "";
    rst_n = 1'b0; cke_n = 1'b0; ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
    we_n = 1'b1; addr = '0; bw_n = '1; oe_n = 1'b0; dq_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dq_t == 1'b0, "R9 reset drive", DW'(dq_t), '0);
    chk(dq_o == '0, "R9 reset data", dq_o, '0);
    rst_n = 1'b1;
    idle(4);

    // R2 R10: fill every word, then R1: read all back-to-back
    for (int a = 0; a < N; a++) step(1'b1, 1'b1, a, '0, pat(a, 0), 1'b1, "R2");
    for (int a = 0; a < N; a++) step(1'b1, 1'b0, a, '1, '0, 1'b1, "R1 R10 read");
    idle(2);

    // R2: byte-masked writes, bw_n sweeps every pattern
    for (int a = 0; a < N; a++) step(1'b1, 1'b1, a, NB'(a), pat(a, 1), 1'b1, "R2");
    for (int a = 0; a < N; a++) step(1'b1, 1'b0, a, '1, '0, 1'b1, "R2 masked read");
    idle(2);

    // R3: strict write/read alternation to other words
    for (int i = 0; i < N; i++) begin
      step(1'b1, 1'b1, i, NB'(i + 1), pat(i, 2), 1'b1, "R3");
      step(1'b1, 1'b0, (i + 5) % N, '1, '0, 1'b1, "R3 alternating read");
    end
    idle(2);

    // R8: read directly after write to the same word, all masks
    for (int i = 0; i < N; i++) begin
      step(1'b1, 1'b1, i, NB'(i), pat(i, 3), 1'b1, "R8");
      step(1'b1, 1'b0, i, '1, '0, 1'b1, "R8 forwarded read");
      step(1'b1, 1'b0, i, '1, '0, 1'b1, "R8 read two behind");
    end
    idle(2);

    // R4: deselected writes change nothing; deselected reads leave bus quiet
    for (int m = 0; m < 3; m++) begin
      desel_mode = m;
      step(1'b0, 1'b1, 3, '0, pat(99, m), 1'b1, "R4");
      step(1'b0, 1'b0, 3, '1, '0, 1'b1, "R4");
      idle(1);
      step(1'b1, 1'b0, 3, '1, '0, 1'b1, "R4 word after deselected write");
      idle(2);
    end

    // R7: freeze during a read slot and with a pending write
    step(1'b1, 1'b0, 6, '1, '0, 1'b1, "R7 read held");
    idle(1);
    step(1'b1, 1'b1, 6, '0, pat(77, 7), 1'b0, "R7");
    step(1'b1, 1'b1, 7, '0, pat(78, 7), 1'b0, "R7");
    idle(2);
    step(1'b1, 1'b0, 6, '1, '0, 1'b1, "R7 frozen write ignored");
    step(1'b1, 1'b0, 7, '1, '0, 1'b1, "R7 frozen write ignored");
    step(1'b1, 1'b1, 9, 2'b10, pat(9, 8), 1'b1, "R7");
    idle(1);
    step(1'b0, 1'b0, 0, '1, '0, 1'b0, "R7");
    step(1'b0, 1'b0, 0, '1, '0, 1'b0, "R7");
    idle(1);
    step(1'b1, 1'b0, 9, '1, '0, 1'b1, "R7 write after freeze");
    idle(2);

    // R6: output enable gates the drivers without a clock edge
    step(1'b1, 1'b0, 5, '1, '0, 1'b1, "R6 read");
    idle(1);
    oe_n = 1'b1; #1;
    chk(dq_t == 1'b0, "R6 async off", DW'(dq_t), '0);
    oe_n = 1'b0; #1;
    chk(dq_t == 1'b1, "R6 async on", DW'(dq_t), DW'(1));
    chk(dq_o == model[5], "R6 data", dq_o, model[5]);
    oe_n = 1'b1;
    idle(1);
    oe_n = 1'b0;
    idle(3);

    done = 1;
    summary();
    $finish;
  end
endmodule